// File: doc/BRIEF.md
# Vector-Add Kernel Control Register File

This block is the host-facing control and argument store of a vector-add accelerator. A processor reaches it over an AXI4-Lite slave port with 32-bit data and a 6-bit byte address. Through it the host loads three 64-bit buffer base addresses and a 32-bit element count, starts the kernel, and releases it between runs. The host can then watch the kernel's done, idle and ready indications by polling or through a single level interrupt line.

The kernel side receives a start level, a one-cycle continue pulse and the four argument values. It returns done, idle and ready. An auto-restart bit keeps the start level asserted across the kernel's ready handshakes, so that back-to-back runs need no further host writes. Interrupts are gated at two levels. Two status flags, one set on done and one set on ready, each have their own enable. A global enable then masks their OR onto the interrupt pin.

The bus side has two small state machines. The write machine moves through `W_IDLE`, `W_DATA` and `W_RESP`. In `W_IDLE` it accepts an address and goes to `W_DATA`. In `W_DATA` it accepts the data beat and goes to `W_RESP`. In `W_RESP` it holds the response until bready and then returns to `W_IDLE`. The read machine moves through `R_IDLE` and `R_RESP`. In `R_IDLE` it accepts an address, captures the data and goes to `R_RESP`. In `R_RESP` it holds the data until rready and then returns to `R_IDLE`. The register core between them has no states of its own, only flags.

Top module: `vadd_ctl_regfile`

## Requirements
- R1: A write is taken as an address beat while awready is high, then a data beat while wready is high, then a response with bresp = 2'b00 that holds bvalid high until bready is seen.
- R2: A read address is accepted while arready is high. rvalid rises on the next cycle with rresp = 2'b00, and rvalid and rdata hold until rready. Offsets 0x18, 0x24, 0x30, 0x38 and 0x3C read as zero, and writes to them change nothing.
- R3: The low and high words of the three base addresses sit at 0x10/0x14 (source 0), 0x1C/0x20 (source 1) and 0x28/0x2C (destination). The element count sits at 0x34. Each of these words honours the write byte strobes, reads back, and drives its output port from the cycle after the write.
- R4: Writing 1 to control bit 0 (offset 0x00) raises krn_start. Writing 0 to that bit does not lower it. With auto-restart clear, krn_start drops in the cycle after krn_ready is seen high. Control bit 0 reads the start level.
- R5: Control bit 7 is the auto-restart flag, set or cleared by each control write. While it is set, krn_ready does not lower krn_start.
- R6: Writing 1 to control bit 4 gives a krn_continue pulse exactly one cycle long, starting the cycle after the data beat. Control bit 4 always reads 0.
- R7: Control bit 1 is set by krn_done and stays set until the control word is read. The read returns the value before clearing. A krn_done in the same cycle as the read's address acceptance leaves the bit set.
- R8: Control bit 2 reads krn_idle and bit 3 reads krn_ready, both as sampled in the cycle the read address is accepted.
- R9: Offset 0x04 bit 0 is the global interrupt enable and offset 0x08 bits 1:0 are the channel enables. At offset 0x0C, status bit 0 is set by krn_done when enable bit 0 is on, and status bit 1 is set by krn_ready when enable bit 1 is on. Writing 1 to a status bit toggles it, and a set event in the same cycle wins.
- R10: irq is high exactly when the global enable is on and at least one status bit is set. Control bit 9 reads the OR of the status bits.
- R11: Writes to offsets 0x00, 0x04, 0x08 and 0x0C take effect only when wstrb bit 0 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 6 | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 6 | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| krn_start | output | 1 | Start level to the kernel |
| krn_continue | output | 1 | One-cycle continue pulse to the kernel |
| krn_done | input | 1 | Kernel finished a run |
| krn_idle | input | 1 | Kernel is idle |
| krn_ready | input | 1 | Kernel can accept a new start |
| krn_src0_base | output | 64 | Base address of the first source buffer |
| krn_src1_base | output | 64 | Base address of the second source buffer |
| krn_dst_base | output | 64 | Base address of the result buffer |
| krn_elem_count | output | 32 | Number of elements to process |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a collision between a kernel event and a host access in the same clock. Two cases matter: krn_done arriving in the very cycle that a control-word read is accepted, and a status toggle write landing together with a status set event. The bench reaches both by driving the read address and the done pulse on the same falling edge while the read machine sits in R_IDLE, so arready is known to be high. It also times a status write so that its data beat meets a krn_ready pulse. A behavioural model that tracks each register is compared against the kernel-side outputs on every clock and against every read response.

// File: rtl/vadd_ctl_pkg.sv
package vadd_ctl_pkg;
    localparam int unsigned BUS_DW     = 32;
    localparam int unsigned BUS_AW     = 6;
    localparam int unsigned BUS_SW     = BUS_DW / 8;
    localparam int unsigned IDX_W      = BUS_AW - 2;
    localparam int unsigned NUM_PTR    = 3;
    localparam int unsigned PTR_W      = 2 * BUS_DW;
    localparam int unsigned PTR_BASE   = 4;
    localparam int unsigned PTR_STRIDE = 3;
    localparam int unsigned CNT_IDX    = PTR_BASE + PTR_STRIDE * NUM_PTR;
    localparam int unsigned NUM_CHAN   = 2;

    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_GIE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_IER  = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_ISR  = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_CNT  = IDX_W'(CNT_IDX);

    // control word bit positions (host software decodes these)
    localparam int unsigned CB_START = 0;
    localparam int unsigned CB_DONE  = 1;
    localparam int unsigned CB_IDLE  = 2;
    localparam int unsigned CB_READY = 3;
    localparam int unsigned CB_CONT  = 4;
    localparam int unsigned CB_AUTO  = 7;
    localparam int unsigned CB_IRQ   = 9;

    typedef enum logic [1:0] {W_IDLE, W_DATA, W_RESP} wr_state_e;
    typedef enum logic [0:0] {R_IDLE, R_RESP} rd_state_e;

    function automatic logic [BUS_DW-1:0] byte_merge(
        input logic [BUS_DW-1:0] cur,
        input logic [BUS_DW-1:0] nxt,
        input logic [BUS_SW-1:0] be
    );
        logic [BUS_DW-1:0] r;
        for (int b = 0; b < int'(BUS_SW); b++) begin
            r[8*b +: 8] = be[b] ? nxt[8*b +: 8] : cur[8*b +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/vadd_ctl_wr_fsm.sv
module vadd_ctl_wr_fsm
    import vadd_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] awaddr_i,
    input  logic              awvalid_i,
    output logic              awready_o,
    input  logic [BUS_DW-1:0] wdata_i,
    input  logic [BUS_SW-1:0] wstrb_i,
    input  logic              wvalid_i,
    output logic              wready_o,
    output logic [1:0]        bresp_o,
    output logic              bvalid_o,
    input  logic              bready_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BUS_DW-1:0] wr_data_o,
    output logic [BUS_SW-1:0] wr_strb_o
);
    wr_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             unused_lsb;

    assign unused_lsb = ^awaddr_i[1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                        idx_q <= '0;
        else if (awvalid_i && awready_o)   idx_q <= awaddr_i[BUS_AW-1:2];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:  if (awvalid_i) state_d = W_DATA;
            W_DATA:  if (wvalid_i)  state_d = W_RESP;
            W_RESP:  if (bready_i)  state_d = W_IDLE;
            default: state_d = W_IDLE;
        endcase
    end

    always_comb begin
        awready_o = (state_q == W_IDLE);
        wready_o  = (state_q == W_DATA);
        bvalid_o  = (state_q == W_RESP);
        bresp_o   = 2'b00;
        wr_en_o   = (state_q == W_DATA) && wvalid_i;
        wr_idx_o  = idx_q;
        wr_data_o = wdata_i;
        wr_strb_o = wstrb_i;
    end

    a_r1_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid_o && !bready_i) |=> bvalid_o);
    a_r1_data_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wready_o) |-> $past(awvalid_i));
endmodule

// File: rtl/vadd_ctl_rd_fsm.sv
module vadd_ctl_rd_fsm
    import vadd_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] araddr_i,
    input  logic              arvalid_i,
    output logic              arready_o,
    output logic [BUS_DW-1:0] rdata_o,
    output logic [1:0]        rresp_o,
    output logic              rvalid_o,
    input  logic              rready_i,
    output logic              rd_en_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    input  logic [BUS_DW-1:0] rd_data_i
);
    rd_state_e         state_q, state_d;
    logic [BUS_DW-1:0] data_q;
    logic              unused_lsb;

    assign unused_lsb = ^araddr_i[1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= R_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (rd_en_o) data_q <= rd_data_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE:  if (arvalid_i) state_d = R_RESP;
            R_RESP:  if (rready_i)  state_d = R_IDLE;
            default: state_d = R_IDLE;
        endcase
    end

    always_comb begin
        arready_o = (state_q == R_IDLE);
        rvalid_o  = (state_q == R_RESP);
        rresp_o   = 2'b00;
        rdata_o   = data_q;
        rd_en_o   = (state_q == R_IDLE) && arvalid_i;
        rd_idx_o  = araddr_i[BUS_AW-1:2];
    end

    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o)));
    a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid_i && arready_o) |=> rvalid_o);
endmodule

// File: rtl/vadd_ctl_regs.sv
module vadd_ctl_regs
    import vadd_ctl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [IDX_W-1:0]         wr_idx_i,
    input  logic [BUS_DW-1:0]        wr_data_i,
    input  logic [BUS_SW-1:0]        wr_strb_i,
    input  logic                     rd_en_i,
    input  logic [IDX_W-1:0]         rd_idx_i,
    output logic [BUS_DW-1:0]        rd_data_o,
    input  logic                     k_done_i,
    input  logic                     k_idle_i,
    input  logic                     k_ready_i,
    output logic                     k_start_o,
    output logic                     k_continue_o,
    output logic [NUM_PTR*PTR_W-1:0] ptr_o,
    output logic [BUS_DW-1:0]        count_o,
    output logic                     irq_o
);
    logic                  start_q, auto_q, cont_q, done_q, gie_q;
    logic [NUM_CHAN-1:0]   ier_q, isr_q, isr_set, isr_tog;
    logic [BUS_DW-1:0]     count_q;
    logic [NUM_PTR-1:0][PTR_W-1:0] ptr_all;
    logic                  lo_wr, ctl_wr, gie_wr, ier_wr, isr_wr, ctl_rd;

    assign lo_wr  = wr_en_i && wr_strb_i[0];
    assign ctl_wr = lo_wr && (wr_idx_i == IDX_CTRL);
    assign gie_wr = lo_wr && (wr_idx_i == IDX_GIE);
    assign ier_wr = lo_wr && (wr_idx_i == IDX_IER);
    assign isr_wr = lo_wr && (wr_idx_i == IDX_ISR);
    assign ctl_rd = rd_en_i && (rd_idx_i == IDX_CTRL);

    assign isr_set = {k_ready_i && ier_q[1], k_done_i && ier_q[0]};
    assign isr_tog = isr_wr ? wr_data_i[NUM_CHAN-1:0] : '0;

    // kernel handshake flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            auto_q  <= 1'b0;
            cont_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (ctl_wr && wr_data_i[CB_START]) start_q <= 1'b1;
            else if (k_ready_i && !auto_q)     start_q <= 1'b0;
            if (ctl_wr) auto_q <= wr_data_i[CB_AUTO];
            cont_q <= ctl_wr && wr_data_i[CB_CONT];
            if (k_done_i)    done_q <= 1'b1;
            else if (ctl_rd) done_q <= 1'b0;
        end
    end

    // interrupt gating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            ier_q <= '0;
            isr_q <= '0;
        end else begin
            if (gie_wr) gie_q <= wr_data_i[0];
            if (ier_wr) ier_q <= wr_data_i[NUM_CHAN-1:0];
            isr_q <= (isr_q ^ isr_tog) | isr_set;
        end
    end

    // buffer base addresses: low word at base, high word at base+1
    for (genvar p = 0; p < int'(NUM_PTR); p++) begin : g_ptr
        localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(PTR_BASE + PTR_STRIDE * p);
        localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(PTR_BASE + PTR_STRIDE * p + 1);
        logic [BUS_DW-1:0] lo_q, hi_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (wr_en_i) begin
                if (wr_idx_i == LO_IDX) lo_q <= byte_merge(lo_q, wr_data_i, wr_strb_i);
                if (wr_idx_i == HI_IDX) hi_q <= byte_merge(hi_q, wr_data_i, wr_strb_i);
            end
        end
        assign ptr_all[p] = {hi_q, lo_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                count_q <= '0;
        else if (wr_en_i && wr_idx_i == IDX_CNT)   count_q <= byte_merge(count_q, wr_data_i, wr_strb_i);
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_idx_i)
            IDX_CTRL: begin
                rd_data_o[CB_START] = start_q;
                rd_data_o[CB_DONE]  = done_q;
                rd_data_o[CB_IDLE]  = k_idle_i;
                rd_data_o[CB_READY] = k_ready_i;
                rd_data_o[CB_AUTO]  = auto_q;
                rd_data_o[CB_IRQ]   = |isr_q;
            end
            IDX_GIE: rd_data_o[0] = gie_q;
            IDX_IER: rd_data_o[NUM_CHAN-1:0] = ier_q;
            IDX_ISR: rd_data_o[NUM_CHAN-1:0] = isr_q;
            IDX_CNT: rd_data_o = count_q;
            default: begin
                for (int p = 0; p < int'(NUM_PTR); p++) begin
                    if (rd_idx_i == IDX_W'(PTR_BASE + PTR_STRIDE * p))
                        rd_data_o = ptr_all[p][BUS_DW-1:0];
                    if (rd_idx_i == IDX_W'(PTR_BASE + PTR_STRIDE * p + 1))
                        rd_data_o = ptr_all[p][PTR_W-1:BUS_DW];
                end
            end
        endcase
    end

    assign k_start_o    = start_q;
    assign k_continue_o = cont_q;
    assign ptr_o        = ptr_all;
    assign count_o      = count_q;
    assign irq_o        = gie_q && (|isr_q);

    a_r4_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (k_start_o && !k_ready_i) |=> k_start_o);
    a_r5_auto_keeps_start: assert property (@(posedge clk) disable iff (!rst_n)
        (k_start_o && auto_q) |=> k_start_o);
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !ctl_rd) |=> done_q);
    a_r9_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (k_done_i && ier_q[0]) |=> isr_q[0]);
    a_r6_continue_single: assert property (@(posedge clk) disable iff (!rst_n)
        k_continue_o |=> !k_continue_o);
endmodule

// File: rtl/vadd_ctl_regfile.sv
module vadd_ctl_regfile
    import vadd_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [BUS_DW-1:0] s_wdata,
    input  logic [BUS_SW-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [BUS_AW-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [BUS_DW-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              krn_start,
    output logic              krn_continue,
    input  logic              krn_done,
    input  logic              krn_idle,
    input  logic              krn_ready,
    output logic [PTR_W-1:0]  krn_src0_base,
    output logic [PTR_W-1:0]  krn_src1_base,
    output logic [PTR_W-1:0]  krn_dst_base,
    output logic [BUS_DW-1:0] krn_elem_count,
    output logic              irq
);
    logic                     wr_en, rd_en;
    logic [IDX_W-1:0]         wr_idx, rd_idx;
    logic [BUS_DW-1:0]        wr_data, rd_data;
    logic [BUS_SW-1:0]        wr_strb;
    logic [NUM_PTR*PTR_W-1:0] ptr_flat;

    vadd_ctl_wr_fsm u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr_i(s_awaddr), .awvalid_i(s_awvalid), .awready_o(s_awready),
        .wdata_i(s_wdata), .wstrb_i(s_wstrb), .wvalid_i(s_wvalid), .wready_o(s_wready),
        .bresp_o(s_bresp), .bvalid_o(s_bvalid), .bready_i(s_bready),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .wr_strb_o(wr_strb)
    );

    vadd_ctl_rd_fsm u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr_i(s_araddr), .arvalid_i(s_arvalid), .arready_o(s_arready),
        .rdata_o(s_rdata), .rresp_o(s_rresp), .rvalid_o(s_rvalid), .rready_i(s_rready),
        .rd_en_o(rd_en), .rd_idx_o(rd_idx), .rd_data_i(rd_data)
    );

    vadd_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
        .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .k_done_i(krn_done), .k_idle_i(krn_idle), .k_ready_i(krn_ready),
        .k_start_o(krn_start), .k_continue_o(krn_continue),
        .ptr_o(ptr_flat), .count_o(krn_elem_count), .irq_o(irq)
    );

    assign krn_src0_base = ptr_flat[0*PTR_W +: PTR_W];
    assign krn_src1_base = ptr_flat[1*PTR_W +: PTR_W];
    assign krn_dst_base  = ptr_flat[2*PTR_W +: PTR_W];
endmodule

// File: tb/tb_vadd_ctl_regfile.sv
module tb_vadd_ctl_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  s_awaddr = '0, s_araddr = '0;
    logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic        krn_start, krn_continue, irq;
    logic        krn_done = 0, krn_idle = 1, krn_ready = 0;
    logic [63:0] krn_src0_base, krn_src1_base, krn_dst_base;
    logic [31:0] krn_elem_count;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vadd_ctl_regfile dut (.*);

    // ---------------- behavioural reference model ----------------
    logic        m_start, m_auto, m_cont, m_done, m_gie;
    logic [1:0]  m_ier, m_isr;
    logic [31:0] m_w [0:15];
    logic [3:0]  m_wa;
    logic [31:0] m_rdata;

    function automatic logic [31:0] mread(input logic [3:0] i);
        case (i)
            4'd0:  return {22'd0, |m_isr, 1'b0, m_auto, 3'b000, krn_ready, krn_idle, m_done, m_start};
            4'd1:  return {31'd0, m_gie};
            4'd2:  return {30'd0, m_ier};
            4'd3:  return {30'd0, m_isr};
            4'd4, 4'd5, 4'd7, 4'd8, 4'd10, 4'd11, 4'd13: return m_w[i];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0; m_auto = 0; m_cont = 0; m_done = 0; m_gie = 0;
            m_ier = 0; m_isr = 0; m_wa = 0; m_rdata = 0;
            for (int i = 0; i < 16; i++) m_w[i] = 0;
        end else begin
            logic rdc, wr, lo;
            logic [1:0] tog;
            rdc = 0;
            if (s_arvalid && s_arready) begin
                m_rdata = mread(s_araddr[5:2]);
                rdc = (s_araddr[5:2] == 4'd0);
            end
            wr  = s_wvalid && s_wready;
            lo  = wr && s_wstrb[0];
            tog = (lo && m_wa == 4'd3) ? s_wdata[1:0] : 2'b00;
            if (lo && m_wa == 4'd0 && s_wdata[0]) m_start = 1;
            else if (krn_ready && !m_auto)        m_start = 0;
            m_cont = lo && m_wa == 4'd0 && s_wdata[4];
            if (krn_done) m_done = 1;
            else if (rdc) m_done = 0;
            m_isr = (m_isr ^ tog) | {krn_ready & m_ier[1], krn_done & m_ier[0]};
            if (lo && m_wa == 4'd0) m_auto = s_wdata[7];
            if (lo && m_wa == 4'd1) m_gie  = s_wdata[0];
            if (lo && m_wa == 4'd2) m_ier  = s_wdata[1:0];
            if (wr && (m_wa inside {4'd4, 4'd5, 4'd7, 4'd8, 4'd10, 4'd11, 4'd13}))
                for (int b = 0; b < 4; b++)
                    if (s_wstrb[b]) m_w[m_wa][8*b +: 8] = s_wdata[8*b +: 8];
            if (s_awvalid && s_awready) m_wa = s_awaddr[5:2];
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison of kernel-side outputs
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R4 krn_start", {63'd0, krn_start}, {63'd0, m_start});
            chk("R6 krn_continue", {63'd0, krn_continue}, {63'd0, m_cont});
            chk("R10 irq", {63'd0, irq}, {63'd0, m_gie & (|m_isr)});
            chk("R3 src0", krn_src0_base, {m_w[5], m_w[4]});
            chk("R3 src1", krn_src1_base, {m_w[8], m_w[7]});
            chk("R3 dst", krn_dst_base, {m_w[11], m_w[10]});
            chk("R3 count", {32'd0, krn_elem_count}, {32'd0, m_w[13]});
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d,
                             input logic [3:0] s = 4'hF, input int bdelay = 0);
        @(negedge clk); s_awaddr = a; s_awvalid = 1;
        while (!s_awready) @(negedge clk);
        @(negedge clk); s_awvalid = 0; s_wdata = d; s_wstrb = s; s_wvalid = 1;
        while (!s_wready) @(negedge clk);
        @(negedge clk); s_wvalid = 0;
        for (int k = 0; k < bdelay; k++) begin
            chk("R1 bvalid held", {63'd0, s_bvalid}, 64'd1);
            @(negedge clk);
        end
        s_bready = 1;
        while (!s_bvalid) @(negedge clk);
        chk("R1 bresp", {62'd0, s_bresp}, 64'd0);
        @(negedge clk); s_bready = 0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d, input int rdelay = 0);
        @(negedge clk); s_araddr = a; s_arvalid = 1;
        while (!s_arready) @(negedge clk);
        @(negedge clk); s_arvalid = 0;
        for (int k = 0; k < rdelay; k++) begin
            chk("R2 rvalid held", {63'd0, s_rvalid}, 64'd1);
            @(negedge clk);
        end
        s_rready = 1;
        while (!s_rvalid) @(negedge clk);
        chk("R2 rdata vs model", {32'd0, s_rdata}, {32'd0, m_rdata});
        chk("R2 rresp", {62'd0, s_rresp}, 64'd0);
        d = s_rdata;
        @(negedge clk); s_rready = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); krn_done = 1; @(negedge clk); krn_done = 0;
    endtask
    task automatic pulse_ready();
        @(negedge clk); krn_ready = 1; @(negedge clk); krn_ready = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // reset state
        bus_read(6'h00, d); chk("R8 reset ctrl idle", {32'd0, d}, 64'h4);
        bus_read(6'h04, d); chk("R9 reset gie", {32'd0, d}, 64'h0);
        // arguments
        bus_write(6'h10, 32'h1111_0000); bus_write(6'h14, 32'h0000_00A1);
        bus_write(6'h1C, 32'h2222_0004); bus_write(6'h20, 32'h0000_00B2);
        bus_write(6'h28, 32'h3333_0008); bus_write(6'h2C, 32'h0000_00C3);
        bus_write(6'h34, 32'd4096);
        bus_write(6'h34, 32'hAABB_CCDD, 4'b0101);
        bus_read(6'h34, d); chk("R3 strobe merge", {32'd0, d}, {32'd0, 32'h00BB_10DD});
        bus_read(6'h20, d); chk("R3 readback", {32'd0, d}, 64'hB2);
        chk("R3 dst port", krn_dst_base, 64'h0000_00C3_3333_0008);
        // unmapped
        bus_write(6'h18, 32'hDEAD_BEEF);
        bus_read(6'h18, d); chk("R2 unmapped 0x18", {32'd0, d}, 64'd0);
        bus_read(6'h3C, d); chk("R2 unmapped 0x3C", {32'd0, d}, 64'd0);
        // start / ready handshake
        bus_write(6'h00, 32'h1, 4'hF, 3);
        chk("R4 start set", {63'd0, krn_start}, 64'd1);
        bus_write(6'h00, 32'h0);
        chk("R4 write0 keeps start", {63'd0, krn_start}, 64'd1);
        pulse_ready();
        chk("R4 ready clears start", {63'd0, krn_start}, 64'd0);
        // auto-restart
        bus_write(6'h00, 32'h81);
        pulse_ready(); pulse_ready();
        chk("R5 auto keeps start", {63'd0, krn_start}, 64'd1);
        bus_read(6'h00, d); chk("R5 auto bit reads", {32'd0, d}, 64'h85);
        bus_write(6'h00, 32'h00);
        pulse_ready();
        chk("R5 start drops after auto cleared", {63'd0, krn_start}, 64'd0);
        // continue pulse
        bus_write(6'h00, 32'h10);
        bus_read(6'h00, d); chk("R6 continue reads 0", {32'd0, d & 32'h10}, 64'd0);
        // done sticky and read clear
        pulse_done();
        bus_read(6'h00, d, 2); chk("R7 done set", {32'd0, d & 32'h2}, 64'h2);
        bus_read(6'h00, d); chk("R7 done cleared by read", {32'd0, d & 32'h2}, 64'h0);
        // done coincident with control read acceptance
        pulse_done();
        @(negedge clk); s_araddr = 6'h00; s_arvalid = 1; krn_done = 1;
        @(negedge clk); s_arvalid = 0; krn_done = 0; s_rready = 1;
        chk("R7 coincident read value", {32'd0, s_rdata & 32'h2}, 64'h2);
        @(negedge clk); s_rready = 0;
        bus_read(6'h00, d); chk("R7 coincident done survives", {32'd0, d & 32'h2}, 64'h2);
        // idle/ready live bits
        krn_idle = 0; krn_ready = 1;
        bus_read(6'h00, d); chk("R8 idle0 ready1", {32'd0, d & 32'hC}, 64'h8);
        krn_idle = 1; krn_ready = 0;
        // interrupts
        bus_write(6'h08, 32'h3); bus_write(6'h04, 32'h1);
        pulse_done();
        chk("R10 irq on done", {63'd0, irq}, 64'd1);
        bus_read(6'h0C, d); chk("R9 status ch0", {32'd0, d}, 64'h1);
        bus_read(6'h00, d); chk("R10 ctrl pending bit", {32'd0, d & 32'h200}, 64'h200);
        bus_write(6'h0C, 32'h1);
        chk("R9 toggle clears ch0", {63'd0, irq}, 64'd0);
        pulse_ready();
        bus_read(6'h0C, d); chk("R9 status ch1", {32'd0, d}, 64'h2);
        bus_write(6'h04, 32'h0);
        chk("R10 global mask", {63'd0, irq}, 64'd0);
        bus_write(6'h0C, 32'h3);
        bus_read(6'h0C, d); chk("R9 toggle both", {32'd0, d}, 64'h1);
        // toggle write colliding with a ready set event
        @(negedge clk); s_awaddr = 6'h0C; s_awvalid = 1;
        @(negedge clk); s_awvalid = 0; s_wdata = 32'h2; s_wstrb = 4'hF; s_wvalid = 1; krn_ready = 1;
        @(negedge clk); s_wvalid = 0; krn_ready = 0; s_bready = 1;
        @(negedge clk); s_bready = 0;
        bus_read(6'h0C, d); chk("R9 set wins over toggle", {32'd0, d}, 64'h3);
        // strobe gating of control-class registers
        bus_write(6'h00, 32'h1, 4'b1110);
        chk("R11 start ignored without strobe0", {63'd0, krn_start}, 64'd0);
        bus_write(6'h08, 32'h0, 4'b0010);
        bus_read(6'h08, d); chk("R11 ier unchanged", {32'd0, d}, 64'h3);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule